// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder with Serially Loaded Bank

This block sits on the 16-bit address bus of an 8-bit sound coprocessor and routes every byte access to a single target. The targets are a local RAM, a sound-chip port, a tone-generator port, and a 32 KB window into a 24-bit main-CPU address space. The block drives the RAM index, a select strobe for each target, a shared write strobe and write data, and a 24-bit external address. It also returns the read data.

A 9-bit bank value sets where the external window points. Software cannot write this value in parallel. Each write to the bank range moves the value one place toward the low end and puts bit 0 of the written byte in at the top. Nine such writes define the whole value. The first bit written ends up at external address bit 15 and the last at bit 23.

An access to the external window raises a request and holds the coprocessor with a wait signal until the main bus acknowledges it. I/O-port cycles are kept apart from memory cycles: they read as all ones and change nothing.

Top module: `cpdec_top`

## Requirements
- R1: A memory access in 0x0000–0x3FFF asserts `ram_sel` and drives `ram_addr` with address bits 12..0, so the 8 KB array appears at 0x0000 and again at 0x2000. A read returns `ram_rdata`.
- R2: A memory access in 0x4000–0x5FFF asserts `snd_sel` for both reads and writes. A read returns `snd_rdata`.
- R3: A memory write in 0x6000–0x60FF replaces the bank value with {wdata bit 0, old bank bits 8..1}. Every other bit of the written byte is ignored.
- R4: A memory write in 0x6100–0x6FFF leaves the bank value unchanged. A memory read anywhere in 0x6000–0x7FFF returns 0x00 and asserts no select.
- R5: A memory write to exactly 0x7F11 asserts `tone_sel` with `tgt_we`. Every other write in 0x7000–0x7FFF asserts no select and no write strobe.
- R6: A memory access in 0x8000–0xFFFF asserts `ext_req` and drives `ext_addr` = {bank value, address bits 14..0} for both reads and writes.
- R7: While `ext_req` is high and `ext_ack` is low, `cp_wait` is high. In the cycle `ext_ack` is high, `cp_wait` is low and a read returns `ext_rdata`.
- R8: With `cp_io` high, a read returns 0xFF. No select, write strobe or request is asserted, and the bank value does not change.
- R9: After a synchronous reset the bank value is zero, so an external access drives `ext_addr` bits 23..15 as zero.
- R10: After nine bank writes carrying bits p[0], p[1], …, p[8] in that order, `ext_addr[23:15]` equals p.
- R11: At most one of `ram_sel`, `snd_sel`, `tone_sel`, `ext_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_req | input | 1 | Access valid this cycle |
| cp_we | input | 1 | 1 = write, 0 = read |
| cp_io | input | 1 | 1 = I/O-port cycle, 0 = memory cycle |
| cp_addr | input | 16 | Coprocessor address |
| cp_wdata | input | 8 | Write data |
| cp_rdata | output | 8 | Read data returned to the coprocessor |
| cp_wait | output | 1 | Holds the coprocessor while an external access is pending |
| tgt_we | output | 1 | Write strobe qualifying any target select |
| tgt_wdata | output | 8 | Write data forwarded to targets |
| ram_sel | output | 1 | Local RAM select |
| ram_addr | output | 13 | Local RAM index |
| ram_rdata | input | 8 | Local RAM read data |
| snd_sel | output | 1 | Sound-chip port select |
| snd_rdata | input | 8 | Sound-chip read data |
| tone_sel | output | 1 | Tone-generator write select |
| ext_req | output | 1 | External window request |
| ext_addr | output | 24 | External 24-bit address |
| ext_ack | input | 1 | External access complete |
| ext_rdata | input | 8 | External read data |

## Verification
The bench keeps the bank value as a full 24-bit integer that is shifted right and masked. On every access it compares that model with the external address. The main function is exercised with several access patterns: a sweep of region boundaries (0x3FFF/0x4000, 0x5FFF/0x6000, 0x60FF/0x6100, 0x7F10/0x7F11/0x7F12, 0x7FFF/0x8000), which separates off-by-one decode faults; bank writes whose data has only upper bits set against writes with bit 0 set, which separates the real shift source from other data bits; and a nine-bit asymmetric pattern, which tells a correct shift direction from a reversed one. External accesses with zero, one and three wait cycles check the hold behaviour. I/O-port cycles at addresses that alias memory targets show that the I/O flag overrides the memory decode.

// File: rtl/cpdec_pkg.sv
package cpdec_pkg;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_SND  = 3'd2,
        TGT_BANK = 3'd3,
        TGT_TONE = 3'd4,
        TGT_EXT  = 3'd5,
        TGT_PORT = 3'd6
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic wr;
    } dec_t;

    localparam logic [15:0] TONE_ADDR = 16'h7F11;
    localparam logic [7:0]  PORT_READ = 8'hFF;
    localparam logic [7:0]  HOLE_READ = 8'h00;

    function automatic tgt_e classify(input logic [15:0] a, input logic we, input logic io);
        tgt_e t;
        if (io)
            t = TGT_PORT;
        else if (a[15])
            t = TGT_EXT;
        else if (a[14] == 1'b0)
            t = TGT_RAM;
        else if (a[13] == 1'b0)
            t = TGT_SND;
        else if (a[12] == 1'b0)
            t = (we && a[11:8] == 4'h0) ? TGT_BANK : TGT_NONE;
        else
            t = (we && a == TONE_ADDR) ? TGT_TONE : TGT_NONE;
        return t;
    endfunction

endpackage

// File: rtl/cpdec_region.sv
module cpdec_region
    import cpdec_pkg::*;
(
    input  logic        req,
    input  logic        we,
    input  logic        io,
    input  logic [15:0] addr,
    output dec_t        dec
);
    always_comb begin
        dec.tgt = req ? classify(addr, we, io) : TGT_NONE;
        dec.wr  = req & we;
    end
endmodule

// File: rtl/cpdec_bank.sv
module cpdec_bank #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (shift_en)
            bank_q <= {din, bank_q[BANK_W-1:1]};
    end

    AST_BANK_LOW_MOVES: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1]));  // R3
endmodule

// File: rtl/cpdec_rdmux.sv
module cpdec_rdmux
    import cpdec_pkg::*;
(
    input  tgt_e       tgt,
    input  logic [7:0] ram_rdata,
    input  logic [7:0] snd_rdata,
    input  logic [7:0] ext_rdata,
    output logic [7:0] rdata
);
    always_comb begin
        unique case (tgt)
            TGT_RAM:  rdata = ram_rdata;
            TGT_SND:  rdata = snd_rdata;
            TGT_EXT:  rdata = ext_rdata;
            TGT_PORT: rdata = PORT_READ;
            default:  rdata = HOLE_READ;
        endcase
    end
endmodule

// File: rtl/cpdec_top.sv
module cpdec_top
    import cpdec_pkg::*;
#(
    parameter int EXT_AW = 24,
    parameter int WIN_AW = 15,
    parameter int RAM_AW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic              cp_io,
    input  logic [15:0]       cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic [7:0]        cp_rdata,
    output logic              cp_wait,
    output logic              tgt_we,
    output logic [7:0]        tgt_wdata,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [7:0]        ram_rdata,
    output logic              snd_sel,
    input  logic [7:0]        snd_rdata,
    output logic              tone_sel,
    output logic              ext_req,
    output logic [EXT_AW-1:0] ext_addr,
    input  logic              ext_ack,
    input  logic [7:0]        ext_rdata
);
    localparam int BANK_W = EXT_AW - WIN_AW;

    dec_t              dec;
    logic [BANK_W-1:0] bank_q;
    logic              bank_shift;

    cpdec_region u_region (
        .req  (cp_req),
        .we   (cp_we),
        .io   (cp_io),
        .addr (cp_addr),
        .dec  (dec)
    );

    assign bank_shift = (dec.tgt == TGT_BANK);

    cpdec_bank #(.BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bank_shift),
        .din      (cp_wdata[0]),
        .bank_q   (bank_q)
    );

    cpdec_rdmux u_rdmux (
        .tgt       (dec.tgt),
        .ram_rdata (ram_rdata),
        .snd_rdata (snd_rdata),
        .ext_rdata (ext_rdata),
        .rdata     (cp_rdata)
    );

    always_comb begin
        ram_sel   = (dec.tgt == TGT_RAM);
        snd_sel   = (dec.tgt == TGT_SND);
        tone_sel  = (dec.tgt == TGT_TONE);
        ext_req   = (dec.tgt == TGT_EXT);
        ram_addr  = cp_addr[RAM_AW-1:0];
        ext_addr  = {bank_q, cp_addr[WIN_AW-1:0]};
        tgt_we    = dec.wr & (ram_sel | snd_sel | tone_sel | ext_req);
        tgt_wdata = cp_wdata;
        cp_wait   = ext_req & ~ext_ack;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_sel, snd_sel, tone_sel, ext_req}));  // R11

    AST_BANK_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        (cp_req && cp_we && !cp_io && cp_addr[15:8] == 8'h60)
        |=> ext_addr[EXT_AW-1] == $past(cp_wdata[0]));  // R3

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cp_req && cp_we && !cp_io && cp_addr[15:8] == 8'h60)
        |=> $stable(ext_addr[EXT_AW-1:WIN_AW]));  // R4

    AST_PORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cp_req && cp_io) |-> (!tgt_we && !ext_req && cp_rdata == 8'hFF));  // R8

    AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cp_wait |-> (ext_req && !ext_ack));  // R7
endmodule

// File: tb/cpdec_top_test.sv
module cpdec_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cp_req, cp_we, cp_io;
    logic [15:0] cp_addr;
    logic [7:0]  cp_wdata;
    logic [7:0]  cp_rdata;
    logic        cp_wait, tgt_we, ram_sel, snd_sel, tone_sel, ext_req;
    logic [7:0]  tgt_wdata;
    logic [12:0] ram_addr;
    logic [23:0] ext_addr;
    logic        ext_ack;
    logic [7:0]  ram_rdata, snd_rdata, ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int model_bank = 0;

    always #4 clk = ~clk;

    cpdec_top uut (
        .clk(clk), .rst(rst), .cp_req(cp_req), .cp_we(cp_we), .cp_io(cp_io),
        .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .cp_wait(cp_wait), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
        .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .snd_sel(snd_sel), .snd_rdata(snd_rdata), .tone_sel(tone_sel),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack),
        .ext_rdata(ext_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access: inputs driven at negedge, outputs sampled mid-phase,
    // model updated after the rising edge that completes the access.
    task automatic access(input bit io, input bit we, input int a, input int d, input int waits);
        int exp_sel;   // 0 none,1 ram,2 snd,3 tone,4 ext
        int exp_rd;
        bit bank_wr;
        @(negedge clk);
        cp_req = 1; cp_io = io; cp_we = we; cp_addr = a[15:0]; cp_wdata = d[7:0]; ext_ack = 0;
        exp_sel = 0; exp_rd = 0; bank_wr = 0;
        if (io) exp_rd = 'hFF;
        else if (a >= 'h8000) begin exp_sel = 4; exp_rd = ext_rdata; end
        else if (a < 'h4000) begin exp_sel = 1; exp_rd = ram_rdata; end
        else if (a < 'h6000) begin exp_sel = 2; exp_rd = snd_rdata; end
        else if (a < 'h7000) bank_wr = we && (a <= 'h60FF);
        else if (we && a == 'h7F11) exp_sel = 3;
        if (exp_sel == 4) begin
            for (int k = 0; k < waits; k++) begin
                #2;
                check("R7 wait", {31'd0, cp_wait}, 1);
                check("R6 addr", ext_addr, model_bank + (a & 'h7FFF));
                @(negedge clk);
            end
            ext_ack = 1;
        end
        #2;
        check("R11 sel", {ram_sel, snd_sel, tone_sel, ext_req},
              exp_sel == 1 ? 8 : exp_sel == 2 ? 4 : exp_sel == 3 ? 2 : exp_sel == 4 ? 1 : 0);
        check("R5 we", {31'd0, tgt_we}, (we && exp_sel != 0) ? 1 : 0);
        if (exp_sel == 1) check("R1 ram_addr", ram_addr, a & 'h1FFF);
        if (exp_sel == 4) begin
            check("R6 ext_addr", ext_addr, model_bank + (a & 'h7FFF));
            check("R7 released", {31'd0, cp_wait}, 0);
        end
        if (!we) check(io ? "R8 port read" : "R4 read", cp_rdata, exp_rd);
        @(posedge clk);
        if (bank_wr) model_bank = ((model_bank >> 1) | ((d & 1) << 23)) & 'hFF8000;
        #1;
        cp_req = 0; ext_ack = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [8:0] pat;
        rst = 1; cp_req = 0; cp_we = 0; cp_io = 0; cp_addr = 0; cp_wdata = 0; ext_ack = 0;
        ram_rdata = 8'hA5; snd_rdata = 8'h3C; ext_rdata = 8'h96;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9: bank zero after reset
        access(0, 0, 'hFFFF, 0, 0);
        check("R9 reset bank", ext_addr[23:15], 0);
        // R1 mirror and boundaries
        access(0, 0, 'h0123, 0, 0);
        access(0, 1, 'h2123, 'h44, 0);
        access(0, 0, 'h3FFF, 0, 0);
        // R2
        access(0, 0, 'h4000, 0, 0);
        access(0, 1, 'h5FFF, 'h12, 0);
        // R4 reads and ignored writes
        access(0, 0, 'h6000, 0, 0);
        access(0, 0, 'h7F11, 0, 0);
        access(0, 1, 'h6100, 'hFF, 0);
        access(0, 1, 'h6FFF, 'h01, 0);
        access(0, 0, 'h8000, 0, 0);
        check("R4 bank unchanged", ext_addr[23:15], 0);
        // R5 tone port
        access(0, 1, 'h7F10, 'h9, 0);
        access(0, 1, 'h7F11, 'h9, 0);
        access(0, 1, 'h7F12, 'h9, 0);
        // R3 bit 0 only: upper bits ignored
        access(0, 1, 'h6000, 'hFE, 0);
        access(0, 1, 'h60FF, 'h01, 0);
        access(0, 0, 'h8001, 0, 1);
        check("R3 top bit", ext_addr[23:22], 2'b10);
        // R8 port cycles aliasing bank and RAM
        access(1, 1, 'h6000, 'h01, 0);
        access(1, 0, 'h0000, 0, 0);
        access(1, 1, 'h7F11, 'h01, 0);
        access(0, 0, 'hC000, 0, 0);
        check("R8 bank unchanged", ext_addr[23:22], 2'b10);
        // R10 nine-bit pattern, first bit lands at bit 15
        pat = 9'b1_0110_0101;
        for (int i = 0; i < 9; i++) access(0, 1, 'h6000 + i * 31, {7'd0, pat[i]}, 0);
        access(0, 0, 'h8000, 0, 3);
        check("R10 pattern", ext_addr[23:15], pat);
        // R6/R7 external write with waits
        access(0, 1, 'hABCD, 'h77, 2);
        access(0, 0, 'h7FFF, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule